// File: doc/BRIEF.md
# PFC Operating State Supervisor

This block picks the operating mode of a boost power-factor controller from a set of comparator decisions that an analog front end has already made. Its inputs are single-bit flags: the supply has crossed its turn-on level, the supply has dropped under its lockout level, the feedback node sits above the open-loop level, the line-sense input sits above its upper or lower brown-out level, and the output bus has reached 85 % or 95 % of its rated value.

Every flag passes through a synchroniser. The synchronised flags then drive a four-state machine with the states OFF, STARTUP, STANDBY and NORMAL. The outputs tell the rest of the controller what to do: whether the power switch may be driven, whether both compensation nodes must be forced to their parked levels, and which soft-start aids are active.

The brown-out decision uses two thresholds. The lower one turns the decision off and the upper one turns it on, and between them the last decision is kept. This stops the controller from chattering between modes when the line voltage sits near a threshold.

Top module: `pfc_mode_supervisor`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block goes to OFF (`state_o` = 2'b00) with `fault_o` = 1, `gate_en_o` = 0, `src_boost_o` = 0 and `lvl_shift_o` = 0. The state encoding is OFF = 00, STARTUP = 01, STANDBY = 10, NORMAL = 11.
- R2: Each flag input passes through two flops before the state logic uses it. A flag change that is stable before rising edge k can first change `state_o` after edge k+2, and can first change a combinational output after edge k+1.
- R3: OFF is left, for STARTUP, only when the synchronised turn-on, feedback-ok and brown-out-upper flags are all 1 and the lockout flag is 0.
- R4: A synchronised lockout flag of 1 sends the machine to OFF at the next edge from any state. This exit takes priority over every other transition.
- R5: In STARTUP or NORMAL, the machine moves to STANDBY when the feedback flag is 0 or the brown-out decision is 0. STANDBY takes priority over the STARTUP-to-NORMAL step.
- R6: STANDBY is left, for NORMAL, only when both the feedback flag and the brown-out-upper flag are 1. A brown-out input that is only above the lower level keeps the machine in STANDBY.
- R7: The brown-out decision resets to 0. It becomes 1 when the upper flag is 1, becomes 0 when the lower flag is 0, and otherwise keeps its previous value.
- R8: `fault_o`, `vcomp_clamp_o` and `icomp_clamp_o` are 1 exactly while the state is OFF or STANDBY.
- R9: `gate_en_o` is 1 only in STARTUP or NORMAL, and it is 0 in every cycle in which the synchronised lockout flag is 1. Because of this, it drops one cycle before the state reaches OFF.
- R10: `src_boost_o` is 1 exactly while the state is STARTUP and the synchronised 85 % flag is 0.
- R11: `lvl_shift_o` is 1 exactly while the state is STARTUP and the synchronised 95 % flag is 0. A 95 % flag of 1 in STARTUP moves the machine to NORMAL at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_on_i | input | 1 | Supply is above the turn-on level |
| vcc_uvlo_i | input | 1 | Supply is below the lockout level |
| fb_ok_i | input | 1 | Feedback is above the open-loop level |
| bo_hi_i | input | 1 | Line sense is above the upper brown-out level |
| bo_lo_i | input | 1 | Line sense is above the lower brown-out level |
| out_85_i | input | 1 | Output has reached 85 % of rated |
| out_95_i | input | 1 | Output is within 5 % of rated |
| state_o | output | 2 | Current state (00 OFF, 01 STARTUP, 10 STANDBY, 11 NORMAL) |
| fault_o | output | 1 | Internal fault indication |
| gate_en_o | output | 1 | Permission to drive the power switch |
| vcomp_clamp_o | output | 1 | Force the voltage-compensation node to ground |
| icomp_clamp_o | output | 1 | Force the current-compensation node to its standby level |
| src_boost_o | output | 1 | Constant-current source to the voltage compensation is active |
| lvl_shift_o | output | 1 | Startup level shift of the voltage compensation is active |

## Verification
The bench first applies a directed power-up sequence. One missing start condition keeps the machine in OFF, and raising the last missing one shows the two-cycle synchroniser delay. Raising the output flags then separates the 85 % aid from the 95 % aid and from the move into NORMAL. Line-sense patterns that sit between the two brown-out levels tell the held decision apart from a fresh one, both on the way down from NORMAL and on the way out of STANDBY. A lockout that arrives together with an open loop checks that OFF wins and that the gate drops one cycle early. A long stretch of random flags, compared every cycle against a behavioural model, then exercises transition combinations that the directed part does not reach.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'b00,
        ST_STARTUP = 2'b01,
        ST_STANDBY = 2'b10,
        ST_NORMAL  = 2'b11
    } sup_state_e;

    // Comparator decisions, after synchronisation
    typedef struct packed {
        logic out_95;
        logic out_85;
        logic bo_lo;
        logic bo_hi;
        logic fb_ok;
        logic vcc_uvlo;
        logic vcc_on;
    } cmp_flags_t;

    localparam int unsigned NUM_FLAGS = $bits(cmp_flags_t);

    function automatic logic is_running(sup_state_e s);
        return (s == ST_STARTUP) || (s == ST_NORMAL);
    endfunction

    function automatic logic is_parked(sup_state_e s);
        return (s == ST_OFF) || (s == ST_STANDBY);
    endfunction

    // Two-threshold decision: the upper flag sets it, a low lower flag clears it
    function automatic logic bo_decide(logic hi, logic lo, logic prev);
        return hi | (lo & prev);
    endfunction

endpackage

// File: rtl/pfc_sync_bank.sv
module pfc_sync_bank #(
    parameter int unsigned WIDTH  = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[LAST];
    end
endmodule

// File: rtl/pfc_brownout_hyst.sv
module pfc_brownout_hyst
    import pfc_sup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic above_hi,
    input  logic above_lo,
    output logic ok_next
);
    logic ok_q;

    assign ok_next = bo_decide(above_hi, above_lo, ok_q);

    always_ff @(posedge clk) begin
        if (rst) ok_q <= 1'b0;
        else     ok_q <= ok_next;
    end
endmodule

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
    import pfc_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmp_flags_t flags,
    input  logic       bo_ok,
    output sup_state_e state
);
    sup_state_e state_d;

    always_comb begin
        state_d = state;
        if (flags.vcc_uvlo) begin
            state_d = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (flags.vcc_on && flags.fb_ok && flags.bo_hi)
                        state_d = ST_STARTUP;
                end
                ST_STANDBY: begin
                    if (flags.fb_ok && flags.bo_hi)
                        state_d = ST_NORMAL;
                end
                default: begin
                    if (!flags.fb_ok || !bo_ok)
                        state_d = ST_STANDBY;
                    else if (state == ST_STARTUP && flags.out_95)
                        state_d = ST_NORMAL;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_d;
    end
endmodule

// File: rtl/pfc_mode_supervisor.sv
module pfc_mode_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_on_i,
    input  logic       vcc_uvlo_i,
    input  logic       fb_ok_i,
    input  logic       bo_hi_i,
    input  logic       bo_lo_i,
    input  logic       out_85_i,
    input  logic       out_95_i,
    output logic [1:0] state_o,
    output logic       fault_o,
    output logic       gate_en_o,
    output logic       vcomp_clamp_o,
    output logic       icomp_clamp_o,
    output logic       src_boost_o,
    output logic       lvl_shift_o
);
    cmp_flags_t flags_raw;
    cmp_flags_t flags_s;
    logic       bo_ok;
    sup_state_e state_q;

    always_comb begin
        flags_raw.vcc_on   = vcc_on_i;
        flags_raw.vcc_uvlo = vcc_uvlo_i;
        flags_raw.fb_ok    = fb_ok_i;
        flags_raw.bo_hi    = bo_hi_i;
        flags_raw.bo_lo    = bo_lo_i;
        flags_raw.out_85   = out_85_i;
        flags_raw.out_95   = out_95_i;
    end

    pfc_sync_bank #(
        .WIDTH  (NUM_FLAGS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (flags_raw),
        .q   (flags_s)
    );

    pfc_brownout_hyst u_bo (
        .clk      (clk),
        .rst      (rst),
        .above_hi (flags_s.bo_hi),
        .above_lo (flags_s.bo_lo),
        .ok_next  (bo_ok)
    );

    pfc_mode_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .flags (flags_s),
        .bo_ok (bo_ok),
        .state (state_q)
    );

    assign state_o       = state_q;
    assign fault_o       = is_parked(state_q);
    assign vcomp_clamp_o = is_parked(state_q);
    assign icomp_clamp_o = is_parked(state_q);
    assign gate_en_o     = is_running(state_q) && !flags_s.vcc_uvlo;
    assign src_boost_o   = (state_q == ST_STARTUP) && !flags_s.out_85;
    assign lvl_shift_o   = (state_q == ST_STARTUP) && !flags_s.out_95;
endmodule

// File: rtl/pfc_mode_supervisor_chk.sv
module pfc_mode_supervisor_chk
    import pfc_sup_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] state,
    input logic       fault,
    input logic       gate_en,
    input logic       src_boost,
    input logic       lvl_shift,
    input cmp_flags_t flags
);
    AST_UVLO_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        flags.vcc_uvlo |=> state == 2'b00); // R4

    AST_UVLO_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
        flags.vcc_uvlo |-> !gate_en); // R9

    AST_FAULT_NO_GATE: assert property (@(posedge clk) disable iff (rst)
        fault |-> !gate_en); // R8

    AST_OFF_EXIT_COND: assert property (@(posedge clk) disable iff (rst)
        (state != 2'b00 && $past(state) == 2'b00) |->
        $past(flags.vcc_on && flags.fb_ok && flags.bo_hi && !flags.vcc_uvlo)); // R3

    AST_STBY_EXIT_COND: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && $past(state) == 2'b10) |->
        $past(flags.fb_ok && flags.bo_hi)); // R6

    AST_NORMAL_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && $past(state) == 2'b01) |-> $past(flags.out_95)); // R11

    AST_BO_LOSS_STBY: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && !flags.bo_lo && !flags.bo_hi && !flags.vcc_uvlo)
        |=> state == 2'b10); // R5

    AST_BOOST_SCOPE: assert property (@(posedge clk) disable iff (rst)
        src_boost |-> (state == 2'b01 && !flags.out_85)); // R10

    AST_SHIFT_SCOPE: assert property (@(posedge clk) disable iff (rst)
        lvl_shift |-> state == 2'b01); // R11
endmodule

bind pfc_mode_supervisor pfc_mode_supervisor_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_o),
    .fault     (fault_o),
    .gate_en   (gate_en_o),
    .src_boost (src_boost_o),
    .lvl_shift (lvl_shift_o),
    .flags     (flags_s)
);

// File: tb/pfc_mode_supervisor_tb.sv
`timescale 1ns/1ps
module pfc_mode_supervisor_tb;
    // raw bit positions: 0 on, 1 uvlo, 2 fb, 3 hi, 4 lo, 5 o85, 6 o95
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [6:0] raw = '0;
    logic [1:0] state;
    logic fault, gate_en, vclamp, iclamp, boost, lshift;
    int vectors = 0;
    int errors = 0;
    bit done = 0;
    bit armed = 0;

    // reference model
    int ms = 0;
    bit mbo = 0;
    logic [6:0] p1 = '0, p2 = '0;

    always #2.5 clk = ~clk;

    pfc_mode_supervisor u_dut (
        .clk(clk), .rst(rst),
        .vcc_on_i(raw[0]), .vcc_uvlo_i(raw[1]), .fb_ok_i(raw[2]),
        .bo_hi_i(raw[3]), .bo_lo_i(raw[4]), .out_85_i(raw[5]), .out_95_i(raw[6]),
        .state_o(state), .fault_o(fault), .gate_en_o(gate_en),
        .vcomp_clamp_o(vclamp), .icomp_clamp_o(iclamp),
        .src_boost_o(boost), .lvl_shift_o(lshift)
    );

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mbo = 0; p1 = '0; p2 = '0; armed = 1;
        end else begin
            bit bo_n;
            int nx;
            bo_n = p2[3] | (p2[4] & mbo);
            nx = ms;
            if (p2[1]) nx = 0;
            else if (ms == 0) begin
                if (p2[0] && p2[2] && p2[3]) nx = 1;
            end else if (ms == 2) begin
                if (p2[2] && p2[3]) nx = 3;
            end else if (!p2[2] || !bo_n) nx = 2;
            else if (ms == 1 && p2[6]) nx = 3;
            mbo = bo_n;
            ms = nx;
            p2 = p1;
            p1 = raw;
        end
    end

    task automatic cmp(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            bit park, run;
            park = (ms == 0 || ms == 2);
            run = (ms == 1 || ms == 3);
            cmp(state, ms, "R3 state");
            cmp(fault, park, "R8 fault");
            cmp(vclamp, park, "R8 vcomp clamp");
            cmp(iclamp, park, "R8 icomp clamp");
            cmp(gate_en, run && !p2[1], "R9 gate");
            cmp(boost, (ms == 1) && !p2[5], "R10 boost");
            cmp(lshift, (ms == 1) && !p2[6], "R11 shift");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        cmp(state, 0, "R1 reset state");
        cmp(fault, 1, "R1 reset fault");
        cmp(gate_en, 0, "R1 reset gate");
        rst = 1'b0;
        // all but the upper brown-out flag
        raw = 7'b0010101;
        step(6);
        cmp(state, 0, "R3 stays OFF without upper flag");
        raw[3] = 1'b1;
        step(2);
        cmp(state, 0, "R2 two-flop delay");
        step(1);
        cmp(state, 1, "R3 STARTUP entry");
        cmp(boost, 1, "R10 boost on");
        cmp(lshift, 1, "R11 shift on");
        raw[5] = 1'b1;
        step(3);
        cmp(boost, 0, "R10 boost off at 85");
        cmp(lshift, 1, "R11 shift still on");
        raw[6] = 1'b1;
        step(2);
        cmp(lshift, 0, "R11 shift off at 95");
        step(1);
        cmp(state, 3, "R11 NORMAL entry");
        // hysteresis hold
        raw[3] = 1'b0;
        step(6);
        cmp(state, 3, "R7 decision held between levels");
        raw[4] = 1'b0;
        step(3);
        cmp(state, 2, "R5 STANDBY on brown-out");
        cmp(fault, 1, "R8 fault in STANDBY");
        raw[4] = 1'b1;
        step(6);
        cmp(state, 2, "R6 stays STANDBY between levels");
        raw[3] = 1'b1;
        step(3);
        cmp(state, 3, "R6 STANDBY exit");
        raw[2] = 1'b0;
        step(3);
        cmp(state, 2, "R5 STANDBY on open loop");
        raw[2] = 1'b1;
        step(3);
        cmp(state, 3, "R6 recover");
        // lockout with open loop together
        raw[1] = 1'b1; raw[2] = 1'b0;
        step(2);
        cmp(gate_en, 0, "R9 gate drops early");
        cmp(state, 3, "R9 state not yet OFF");
        step(1);
        cmp(state, 0, "R4 OFF wins over STANDBY");
        raw[1] = 1'b0; raw[2] = 1'b1;
        step(3);
        cmp(state, 1, "R3 restart");
        step(1);
        cmp(state, 3, "R11 quick NORMAL");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            raw = 7'($urandom);
            if ($urandom_range(3) != 0) raw[1] = 1'b0;
            step($urandom_range(1, 4));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule